// File: doc/BRIEF.md
# Dual-Order Burst Offset Sequencer

This block drives the two lowest address bits of a pipelined burst memory. When either of two independent address strobes is seen high at a rising clock edge, it registers the presented address. The low bits of that address become the start offset of a four-beat burst, and the remaining bits are held and passed through as the upper address. After that, each cycle in which the advance input is high moves the offset one step along the burst. A cycle with advance low holds the offset, which suspends the burst. Four steps bring the offset back to where it started.

Two orders are supported, and a static order input picks between them. With the order input high (interleaved), the offset is the start offset XOR a step count that runs 0 to 3. With the input low (linear), the offset is the start offset plus the step count, modulo 4. A strobe always reloads the start offset and clears the step count, also in the middle of a burst. The outputs come straight from registers, so a change in the inputs shows at the outputs one clock edge later.

Top module: `burst_offset_seq`

## Requirements
- R1: While reset (rst_ni low) is applied and after it is released, offset_o is 0 and upper_o is 0 until the first strobe.
- R2: When strb_cpu_i is high at a rising edge, after that edge offset_o equals addr_i[1:0] and upper_o equals addr_i[ADDR_W-1:2].
- R3: strb_ctl_i loads exactly as strb_cpu_i does. Both strobes high together give the same single load.
- R4: With order_i = 1 (interleaved), after k advances since the load, offset_o equals start XOR k. For example, start 1 gives 1,0,3,2 and start 2 gives 2,3,0,1.
- R5: With order_i = 0 (linear), after k advances since the load, offset_o equals (start + k) mod 4. For example, start 3 gives 3,0,1,2.
- R6: In an edge with both strobes low and adv_i low, offset_o and upper_o do not change.
- R7: A strobe in the same edge as adv_i is a load and not a step. A load in the middle of a burst restarts the sequence at step 0 from the new start offset.
- R8: The fourth advance after a load returns offset_o to the start offset, in either order.
- R9: With both strobes low, addr_i is ignored: upper_o does not change and offset_o follows only the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| order_i | input | 1 | Static burst order: 1 interleaved, 0 linear |
| strb_cpu_i | input | 1 | Processor-side address strobe, active high |
| strb_ctl_i | input | 1 | Controller-side address strobe, active high |
| adv_i | input | 1 | Advance the burst by one step |
| addr_i | input | ADDR_W | Full start address, sampled on a strobe |
| offset_o | output | 2 | Current burst offset |
| upper_o | output | ADDR_W-2 | Upper address bits held from the last load |

## Verification
A load and a step can be requested in the same edge, because a strobe may arrive while adv_i is high. This happens in the middle of an interleaved burst and again with both strobes and advance high together. In both cases the bench checks that the new start offset appears unchanged on offset_o and that the next advance gives the step-1 value from that start, not a continuation of the old burst. The bench also applies a new addr_i with no strobe and checks that upper_o does not change.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
   typedef enum logic {
      ORD_LINEAR     = 1'b0,
      ORD_INTERLEAVE = 1'b1
   } burst_order_e;
endpackage

// File: rtl/burst_load_reg.sv
module burst_load_reg #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned OFF_W  = 2,
   localparam int unsigned UP_W  = ADDR_W - OFF_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [OFF_W-1:0]  start_o,
   output logic [UP_W-1:0]   upper_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         start_o <= '0;
         upper_o <= '0;
      end else if (load_i) begin
         start_o <= addr_i[OFF_W-1:0];
         upper_o <= addr_i[ADDR_W-1:OFF_W];
      end
   end

   p_upper_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(upper_o));
   p_load_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> upper_o == $past(addr_i[ADDR_W-1:OFF_W]));
endmodule

// File: rtl/burst_step_cnt.sv
module burst_step_cnt #(
   parameter int unsigned OFF_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             adv_i,
   output logic [OFF_W-1:0] cnt_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni)      cnt_o <= '0;
      else if (load_i)  cnt_o <= '0;
      else if (adv_i)   cnt_o <= cnt_o + 1'b1;
   end

   p_load_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cnt_o == '0);
   p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && adv_i) |=> cnt_o == $past(cnt_o) + 1'b1);
   p_hold_cnt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !adv_i) |=> $stable(cnt_o));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
   import burst_seq_pkg::*;
#(
   parameter int unsigned OFF_W = 2
) (
   input  burst_order_e     order_i,
   input  logic [OFF_W-1:0] start_i,
   input  logic [OFF_W-1:0] cnt_i,
   output logic [OFF_W-1:0] offset_o
);
   logic [OFF_W-1:0] xor_off;
   logic [OFF_W-1:0] add_off;

   assign xor_off = start_i ^ cnt_i;

   generate
      if (OFF_W == 1) begin : g_single
         // one-bit offsets: sum modulo 2 and XOR coincide
         assign add_off = xor_off;
      end else begin : g_wide
         assign add_off = start_i + cnt_i;
      end
   endgenerate

   always_comb begin
      offset_o = (order_i == ORD_INTERLEAVE) ? xor_off : add_off;
   end
endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq
   import burst_seq_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   localparam int unsigned OFF_W = 2,
   localparam int unsigned UP_W  = ADDR_W - OFF_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              order_i,
   input  logic              strb_cpu_i,
   input  logic              strb_ctl_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [OFF_W-1:0]  offset_o,
   output logic [UP_W-1:0]   upper_o
);
   generate
      if (ADDR_W <= OFF_W) begin : g_bad_width
         $error("burst_offset_seq: ADDR_W must exceed the offset width");
      end
   endgenerate

   logic             load;
   logic [OFF_W-1:0] start_q;
   logic [OFF_W-1:0] cnt_q;
   burst_order_e     order;

   assign load  = strb_cpu_i | strb_ctl_i;
   assign order = burst_order_e'(order_i);

   burst_load_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_load (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load),
      .addr_i  (addr_i),
      .start_o (start_q),
      .upper_o (upper_o)
   );

   burst_step_cnt #(.OFF_W(OFF_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .adv_i  (adv_i),
      .cnt_o  (cnt_q)
   );

   burst_order_map #(.OFF_W(OFF_W)) u_map (
      .order_i  (order),
      .start_i  (start_q),
      .cnt_i    (cnt_q),
      .offset_o (offset_o)
   );

   p_load_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load |=> offset_o == $past(addr_i[OFF_W-1:0]));
   p_linear_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load && adv_i && !order_i) |=> offset_o == $past(offset_o) + 1'b1);
   p_hold_offset_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load && !adv_i) |=> $stable(offset_o));
   p_reset_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (offset_o == '0 && upper_o == '0));
endmodule

// File: tb/burst_offset_seq_tb.sv
module burst_offset_seq_tb_top;
   localparam int AW = 8;
   localparam int NV = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          order = 1'b1;
   logic          s_cpu = 1'b0;
   logic          s_ctl = 1'b0;
   logic          adv = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    off;
   logic [AW-3:0] up;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   burst_offset_seq #(.ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .order_i(order),
      .strb_cpu_i(s_cpu), .strb_ctl_i(s_ctl), .adv_i(adv),
      .addr_i(addr), .offset_o(off), .upper_o(up)
   );

   // {order, cpu, ctl, adv, addr[7:0], exp_offset[1:0], exp_upper[5:0]}
   localparam logic [19:0] VEC [NV] = '{
      {4'b1100, 8'h55, 2'd1, 6'h15},  // R2 load, interleaved start 1
      {4'b1001, 8'h00, 2'd0, 6'h15},  // R4
      {4'b1001, 8'h00, 2'd3, 6'h15},  // R4
      {4'b1000, 8'h00, 2'd3, 6'h15},  // R6 hold
      {4'b1001, 8'h00, 2'd2, 6'h15},  // R4
      {4'b1001, 8'h00, 2'd1, 6'h15},  // R8 wrap to start
      {4'b1010, 8'hA2, 2'd2, 6'h28},  // R3 ctl strobe load
      {4'b1001, 8'h00, 2'd3, 6'h28},  // R4
      {4'b1001, 8'h00, 2'd0, 6'h28},  // R4
      {4'b1101, 8'h07, 2'd3, 6'h01},  // R7 load with advance mid-burst
      {4'b1001, 8'h00, 2'd2, 6'h01},  // R7 restart at step 1
      {4'b0100, 8'hFB, 2'd3, 6'h3E},  // R2 linear start 3
      {4'b0001, 8'h00, 2'd0, 6'h3E},  // R5
      {4'b0001, 8'h00, 2'd1, 6'h3E},  // R5
      {4'b0000, 8'h00, 2'd1, 6'h3E},  // R6 hold
      {4'b0001, 8'h00, 2'd2, 6'h3E},  // R5
      {4'b0001, 8'h00, 2'd3, 6'h3E},  // R8 wrap
      {4'b0010, 8'h40, 2'd0, 6'h10},  // R3 ctl strobe linear
      {4'b0001, 8'h00, 2'd1, 6'h10},  // R5
      {4'b0111, 8'h12, 2'd2, 6'h04},  // R3 R7 both strobes with advance
      {4'b0001, 8'hFF, 2'd3, 6'h04}   // R9 address ignored
   };

   task automatic check(input string req, input logic [1:0] eo, input logic [AW-3:0] eu);
      checks++;
      if (off !== eo || up !== eu) begin
         errors++;
         $display("FAIL %s: offset=%0d upper=%0h expected offset=%0d upper=%0h",
                  req, off, up, eo, eu);
      end
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 in reset", 2'd0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 2'd0, '0);
      for (int i = 0; i < NV; i++) begin
         {order, s_cpu, s_ctl, adv, addr} = VEC[i][19:8];
         @(posedge clk);
         #1;
         check($sformatf("vector %0d (R2-R9)", i), VEC[i][7:6], VEC[i][5:0]);
         @(negedge clk);
      end
      s_cpu = 1'b0; s_ctl = 1'b0; adv = 1'b0;
      // R9: new address with no strobe and no advance changes nothing
      addr = 8'hC3;
      @(posedge clk); #1;
      check("R9 hold with new addr", 2'd3, 6'h04);
      @(negedge clk);
      // R8: four interleaved advances from start 2 come back to 2
      order = 1'b1; s_cpu = 1'b1; addr = 8'h06;
      @(negedge clk);
      s_cpu = 1'b0; adv = 1'b1;
      repeat (4) @(negedge clk);
      adv = 1'b0;
      check("R8 interleaved wrap", 2'd2, 6'h01);
      // R1: reset in the middle of a burst
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 mid-run reset", 2'd0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule